// File: doc/BRIEF.md
# I2C Slave Address Matcher

This block is the receive-side front end of an I2C slave. SCL and SDA pass through a two-flop synchroniser on the system clock, and START and STOP conditions are found in the resynchronised signals. Each byte is shifted in and compared with a programmable own-address register, or with the reserved general call value. The block pulls SDA low during the acknowledge clock when it accepts a byte, and places accepted bytes in a one-byte receive buffer. Status flags and an interrupt flag go to a simple register interface.

The block supports 7-bit and 10-bit addressing. In 10-bit mode software rewrites the own-address register between the first and second address bytes. When the enable is set, a general call (first byte 0x00) is accepted in either mode. In 10-bit mode it skips the second address byte and the address-update handshake.

The control FSM has five states. ST_IDLE waits for a START. ST_ADDR_HI judges the first address byte. ST_ADDR_LO judges the 10-bit second byte. ST_DATA accepts data bytes. ST_SKIP ignores the bus.

Any state goes to ST_ADDR_HI on START and to ST_IDLE on STOP, and STOP wins if both occur. When a byte completes in ST_ADDR_HI, the block moves as follows:
- A general call or a 7-bit hit goes to ST_DATA.
- A 10-bit first-byte hit goes to ST_ADDR_LO.
- Anything else goes to ST_SKIP.

When a byte completes in ST_ADDR_LO, a full match goes to ST_DATA and anything else goes to ST_SKIP. ST_DATA stays in ST_DATA on each byte. ST_IDLE and ST_SKIP hold until START or STOP.

Top module: `i2c_addr_slave`

## Requirements
- R1: After reset, SDA is released, every flag is 0, the receive buffer is 0x00 and the own-address register holds its reset parameter.
- R2: In 7-bit mode, a first byte whose bits [7:1] equal own-address bits [7:1] and whose bit 0 (R/W) is 0 is acknowledged. The byte goes into the buffer and buffer-full is set. A first byte with R/W = 1 is not acknowledged.
- R3: A first byte that matches nothing is not acknowledged and raises no flag. All further bytes are ignored, and SDA stays released, until the next START.
- R4: A first byte of 0x00 is acknowledged and stored as 0x00 only when general-call enable is 1. With the enable at 0 it is not acknowledged.
- R5: In 10-bit mode, a first byte of the form 11110 a9 a8 0 is acknowledged when a9 a8 equal own-address bits [2:1], and the address-update flag is set. A write to the own-address register clears that flag. A second byte equal to the whole own-address register is acknowledged and opens data reception. A second byte that differs is not acknowledged.
- R6: In 10-bit mode with general call enabled, a first byte of 0x00 leaves address-update at 0. The next byte is accepted as data.
- R7: For every byte the block takes part in (acknowledged, or refused for overflow), the interrupt flag rises after the falling edge of the ninth SCL pulse. It stays set until a flag-clear pulse.
- R8: A one-cycle read strobe clears buffer-full.
- R9: When a byte completes while buffer-full is set, the byte is not acknowledged and the buffer keeps its old value. The overflow flag is set and stays set until a flag-clear pulse.
- R10: A read strobe in the same cycle as a byte completes frees the buffer for that byte. The byte is acknowledged and stored, buffer-full stays 1, and no overflow is flagged.
- R11: SDA is pulled low only from the eighth SCL falling edge to the ninth SCL falling edge of an acknowledged byte, and is released afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin (wired-AND level) |
| sda_pull_o | output | 1 | 1 = drive SDA low (open-drain enable) |
| ten_bit_i | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gc_en_i | input | 1 | General call enable |
| own_wr_i | input | 1 | Write strobe for the own-address register |
| own_wdata_i | input | BYTE_W | Value written into the own-address register |
| rxbuf_rd_i | input | 1 | Receive-buffer read strobe (clears buffer-full) |
| flag_clr_i | input | 1 | Clears the interrupt and overflow flags |
| rxbuf_o | output | BYTE_W | Receive buffer contents |
| buf_full_o | output | 1 | Buffer-full flag |
| addr_upd_o | output | 1 | Own-address must be rewritten for the 10-bit second byte |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt flag |

## Verification
A read strobe that clears the buffer and a byte completion that fills it can fall in the same system clock cycle. In that case the completion must win: the byte is stored and acknowledged with no overflow. The bench raises the read strobe exactly three clocks after it drives the eighth SCL rising edge, which is the cycle the completed byte is judged. It then checks the acknowledge on the bus, the stored value, buffer-full still at 1 and the overflow flag still at 0. A strobe that arrives one cycle late would instead show a NACK and an overflow.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_SKIP
    } slv_state_t;

    // Upper five bits of a 10-bit first address byte
    localparam logic [4:0] TENBIT_TAG = 5'b11110;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] lvl_o,
    output logic [LINES-1:0] rise_o,
    output logic [LINES-1:0] fall_o
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
            logic [STAGES:0] pipe;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '1;
                else        pipe <= {pipe[STAGES-1:0], raw_i[g]};
            end
            assign lvl_o[g]  = pipe[STAGES-1];
            assign rise_o[g] = pipe[STAGES-1] & ~pipe[STAGES];
            assign fall_o[g] = ~pipe[STAGES-1] & pipe[STAGES];
        end
    endgenerate
endmodule

// File: rtl/i2cs_shift.sv
module i2cs_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] data_o,
    output logic              byte_done_o,
    output logic              ack_open_o,
    output logic              ack_close_o
);
    localparam int CW = $clog2(BYTE_W + 2);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);
    localparam logic [CW-1:0] ACK_SLOT = CW'(BYTE_W);
    localparam logic [CW-1:0] ACK_HIGH = CW'(BYTE_W + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            data_o      <= '0;
            byte_done_o <= 1'b0;
            ack_open_o  <= 1'b0;
            ack_close_o <= 1'b0;
        end else begin
            byte_done_o <= 1'b0;
            ack_open_o  <= 1'b0;
            ack_close_o <= 1'b0;
            if (clear_i) begin
                cnt_q <= '0;
            end else if (scl_rise_i) begin
                if (cnt_q < ACK_SLOT) data_o <= {data_o[BYTE_W-2:0], sda_i};
                if (cnt_q == LAST_BIT) byte_done_o <= 1'b1;
                if (cnt_q != ACK_HIGH) cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
                if (cnt_q == ACK_SLOT) ack_open_o <= 1'b1;
                if (cnt_q == ACK_HIGH) begin
                    cnt_q       <= '0;
                    ack_close_o <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
    import i2cs_pkg::*;
#(
    parameter int                BYTE_W      = 8,
    parameter int                SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] RESET_ADDR  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_pull_o,
    input  logic              ten_bit_i,
    input  logic              gc_en_i,
    input  logic              own_wr_i,
    input  logic [BYTE_W-1:0] own_wdata_i,
    input  logic              rxbuf_rd_i,
    input  logic              flag_clr_i,
    output logic [BYTE_W-1:0] rxbuf_o,
    output logic              buf_full_o,
    output logic              addr_upd_o,
    output logic              ovf_o,
    output logic              irq_o
);
    localparam int SCL_IDX = 1;
    localparam int SDA_IDX = 0;

    logic [1:0] lvl, rise, fall;
    logic start_det, stop_det;
    logic [BYTE_W-1:0] shreg, own_q;
    logic byte_done, ack_open, ack_close;
    slv_state_t state_q, state_d;
    logic gc_hit, hit7, hit10a, hit10b, take, accept, buf_busy;
    logic ack_ok_q, irq_pend_q;

    i2cs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({scl_i, sda_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    assign start_det = lvl[SCL_IDX] & fall[SDA_IDX];
    assign stop_det  = lvl[SCL_IDX] & rise[SDA_IDX];

    i2cs_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start_det | stop_det),
        .scl_rise_i  (rise[SCL_IDX]),
        .scl_fall_i  (fall[SCL_IDX]),
        .sda_i       (lvl[SDA_IDX]),
        .data_o      (shreg),
        .byte_done_o (byte_done),
        .ack_open_o  (ack_open),
        .ack_close_o (ack_close)
    );

    // Address comparison
    always_comb begin
        gc_hit = gc_en_i && (shreg == '0);
        hit7   = !ten_bit_i && !shreg[0] && (shreg[BYTE_W-1:1] == own_q[BYTE_W-1:1]);
        hit10a = ten_bit_i && !shreg[0] && (shreg[BYTE_W-1:BYTE_W-5] == TENBIT_TAG)
                 && (shreg[2:1] == own_q[2:1]);
        hit10b = (shreg == own_q);
        take   = 1'b0;
        unique case (state_q)
            ST_ADDR_HI: take = byte_done && (gc_hit || hit7 || hit10a);
            ST_ADDR_LO: take = byte_done && hit10b;
            ST_DATA:    take = byte_done;
            default:    take = 1'b0;
        endcase
        buf_busy = buf_full_o && !rxbuf_rd_i;
        accept   = take && !buf_busy;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (stop_det) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR_HI;
        end else if (byte_done) begin
            unique case (state_q)
                ST_ADDR_HI: begin
                    if (gc_hit || hit7) state_d = ST_DATA;
                    else if (hit10a)    state_d = ST_ADDR_LO;
                    else                state_d = ST_SKIP;
                end
                ST_ADDR_LO: state_d = hit10b ? ST_DATA : ST_SKIP;
                ST_DATA:    state_d = ST_DATA;
                default:    state_d = state_q;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q      <= RESET_ADDR;
            rxbuf_o    <= '0;
            buf_full_o <= 1'b0;
            addr_upd_o <= 1'b0;
            ovf_o      <= 1'b0;
            irq_o      <= 1'b0;
            ack_ok_q   <= 1'b0;
            irq_pend_q <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            if (own_wr_i) begin
                own_q      <= own_wdata_i;
                addr_upd_o <= 1'b0;
            end
            if (rxbuf_rd_i) buf_full_o <= 1'b0;
            if (flag_clr_i) begin
                irq_o <= 1'b0;
                ovf_o <= 1'b0;
            end
            if (byte_done) begin
                irq_pend_q <= take;
                ack_ok_q   <= accept;
                if (accept) begin
                    rxbuf_o    <= shreg;
                    buf_full_o <= 1'b1;
                    if (state_q == ST_ADDR_HI && hit10a && !gc_hit) addr_upd_o <= 1'b1;
                end else if (take) begin
                    ovf_o <= 1'b1;
                end
            end
            if (ack_open) sda_pull_o <= ack_ok_q;
            if (ack_close) begin
                sda_pull_o <= 1'b0;
                irq_pend_q <= 1'b0;
                if (irq_pend_q) irq_o <= 1'b1;
            end
            if (start_det || stop_det) begin
                sda_pull_o <= 1'b0;
                irq_pend_q <= 1'b0;
                ack_ok_q   <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rxbuf_rd_i,
    input logic              flag_clr_i,
    input logic [BYTE_W-1:0] rxbuf_o,
    input logic              buf_full_o,
    input logic              addr_upd_o,
    input logic              ovf_o,
    input logic              irq_o
);
    AST_BUF_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxbuf_o) |-> buf_full_o); // R2

    AST_UPD_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_upd_o) |-> buf_full_o); // R5

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !flag_clr_i) |=> irq_o); // R7

    AST_FULL_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(buf_full_o) |-> $past(rxbuf_rd_i)); // R8

    AST_OVF_KEEPS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> (rxbuf_o == $past(rxbuf_o))); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !flag_clr_i) |=> ovf_o); // R9
endmodule

bind i2c_addr_slave i2cs_checker #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxbuf_rd_i (rxbuf_rd_i),
    .flag_clr_i (flag_clr_i),
    .rxbuf_o    (rxbuf_o),
    .buf_full_o (buf_full_o),
    .addr_upd_o (addr_upd_o),
    .ovf_o      (ovf_o),
    .irq_o      (irq_o)
);

// File: tb/i2c_addr_slave_tb.sv
`timescale 1ns/1ps
module i2c_addr_slave_tb;
    localparam int HALF = 20; // system clocks per SCL half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull;
    logic ten_bit = 1'b0, gc_en = 1'b0, own_wr = 1'b0, rd = 1'b0, fclr = 1'b0;
    logic [7:0] own_wdata = 8'h00;
    logic [7:0] rxbuf;
    logic buf_full, addr_upd, ovf, irq;

    int n_checks = 0;
    int n_fail = 0;
    int bitn = 0;
    bit done = 1'b0;
    bit exp_ack_q[$];
    string req_q[$];

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_addr_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull),
        .ten_bit_i   (ten_bit),
        .gc_en_i     (gc_en),
        .own_wr_i    (own_wr),
        .own_wdata_i (own_wdata),
        .rxbuf_rd_i  (rd),
        .flag_clr_i  (fclr),
        .rxbuf_o     (rxbuf),
        .buf_full_o  (buf_full),
        .addr_upd_o  (addr_upd),
        .ovf_o       (ovf),
        .irq_o       (irq)
    );

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
        bitn = 0;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        sda_m = 1'b1; wait_clk(HALF);
    endtask

    // Driver: pushes the expected acknowledge, then clocks the byte out
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req, input bit rd_sync);
        exp_ack_q.push_back(exp_ack);
        req_q.push_back(req);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(HALF);
            scl_m = 1'b1;
            if (rd_sync && i == 0) begin
                wait_clk(3); rd = 1'b1;
                wait_clk(1); rd = 1'b0;
                wait_clk(HALF - 4);
            end else begin
                wait_clk(HALF);
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b1; wait_clk(HALF);
        scl_m = 1'b0; wait_clk(HALF);
    endtask

    task automatic pulse_rd();   rd = 1'b1;   wait_clk(1); rd = 1'b0;   wait_clk(1); endtask
    task automatic pulse_clr();  fclr = 1'b1; wait_clk(1); fclr = 1'b0; wait_clk(1); endtask
    task automatic write_own(input logic [7:0] v);
        own_wdata = v; own_wr = 1'b1; wait_clk(1); own_wr = 1'b0; wait_clk(1);
    endtask

    // Monitor: at the ninth SCL high of each byte, compare the line with the queue
    always @(posedge scl_m) begin
        bitn = bitn + 1;
        if (bitn == 9) begin
            bitn = 0;
            repeat (HALF / 2) @(negedge clk);
            if (exp_ack_q.size() > 0) begin
                automatic bit e = exp_ack_q.pop_front();
                automatic string r = req_q.pop_front();
                check((!sda_line) == e, r, {7'd0, !sda_line}, {7'd0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        // R1 reset state
        check(sda_pull == 1'b0, "R1 sda", {7'd0, sda_pull}, 8'h00);
        check({buf_full, addr_upd, ovf, irq} == 4'b0, "R1 flags", {4'd0, buf_full, addr_upd, ovf, irq}, 8'h00);
        check(rxbuf == 8'h00, "R1 rxbuf", rxbuf, 8'h00);

        // R2 7-bit match, R7 interrupt, R8 read
        write_own(8'hA4);
        i2c_start();
        send_byte(8'hA4, 1'b1, "R2 ack", 1'b0);
        check(rxbuf == 8'hA4, "R2 rxbuf", rxbuf, 8'hA4);
        check(buf_full == 1'b1, "R2 full", {7'd0, buf_full}, 8'h01);
        check(irq == 1'b1, "R7 irq set", {7'd0, irq}, 8'h01);
        check(sda_pull == 1'b0, "R11 released", {7'd0, sda_pull}, 8'h00);
        wait_clk(30);
        check(irq == 1'b1, "R7 irq held", {7'd0, irq}, 8'h01);
        pulse_clr();
        check(irq == 1'b0, "R7 irq cleared", {7'd0, irq}, 8'h00);
        pulse_rd();
        check(buf_full == 1'b0, "R8 read clears", {7'd0, buf_full}, 8'h00);
        send_byte(8'h3C, 1'b1, "R2 data ack", 1'b0);
        check(rxbuf == 8'h3C, "R2 data", rxbuf, 8'h3C);
        // R9 overflow
        send_byte(8'h5A, 1'b0, "R9 nack", 1'b0);
        check(ovf == 1'b1, "R9 ovf", {7'd0, ovf}, 8'h01);
        check(rxbuf == 8'h3C, "R9 buffer kept", rxbuf, 8'h3C);
        check(sda_pull == 1'b0, "R11 nack released", {7'd0, sda_pull}, 8'h00);
        i2c_stop();
        wait_clk(20);
        check(ovf == 1'b1, "R9 sticky", {7'd0, ovf}, 8'h01);
        pulse_clr();
        check(ovf == 1'b0, "R9 cleared", {7'd0, ovf}, 8'h00);
        pulse_rd();

        // R3 mismatch and R2 read direction refused
        i2c_start();
        send_byte(8'hB4, 1'b0, "R3 nack", 1'b0);
        send_byte(8'hA4, 1'b0, "R3 ignored", 1'b0);
        check({buf_full, irq, ovf} == 3'b0, "R3 no flags", {5'd0, buf_full, irq, ovf}, 8'h00);
        check(rxbuf == 8'h3C, "R3 buffer kept", rxbuf, 8'h3C);
        i2c_start();
        send_byte(8'hA5, 1'b0, "R2 read nack", 1'b0);
        i2c_stop();

        // R4 general call
        i2c_start();
        send_byte(8'h00, 1'b0, "R4 disabled nack", 1'b0);
        i2c_stop();
        gc_en = 1'b1;
        i2c_start();
        send_byte(8'h00, 1'b1, "R4 enabled ack", 1'b0);
        check(rxbuf == 8'h00 && buf_full, "R4 stored", rxbuf, 8'h00);
        pulse_rd(); pulse_clr();
        send_byte(8'h77, 1'b1, "R4 data ack", 1'b0);
        check(rxbuf == 8'h77, "R4 data", rxbuf, 8'h77);
        i2c_stop();
        pulse_rd(); pulse_clr();
        gc_en = 1'b0;

        // R5 10-bit handshake
        ten_bit = 1'b1;
        write_own(8'h06);
        i2c_start();
        send_byte(8'hF6, 1'b1, "R5 first ack", 1'b0);
        check(addr_upd == 1'b1, "R5 upd set", {7'd0, addr_upd}, 8'h01);
        check(rxbuf == 8'hF6, "R5 first stored", rxbuf, 8'hF6);
        pulse_rd(); pulse_clr();
        write_own(8'h9D);
        check(addr_upd == 1'b0, "R5 upd cleared", {7'd0, addr_upd}, 8'h00);
        send_byte(8'h9D, 1'b1, "R5 second ack", 1'b0);
        pulse_rd(); pulse_clr();
        send_byte(8'h42, 1'b1, "R5 data ack", 1'b0);
        check(rxbuf == 8'h42, "R5 data", rxbuf, 8'h42);
        i2c_stop();
        pulse_rd(); pulse_clr();
        write_own(8'h06);
        i2c_start();
        send_byte(8'hF6, 1'b1, "R5 first ack again", 1'b0);
        pulse_rd(); pulse_clr();
        send_byte(8'h9D, 1'b0, "R5 second mismatch nack", 1'b0);
        i2c_stop();
        write_own(8'h06);

        // R6 general call in 10-bit mode
        gc_en = 1'b1;
        i2c_start();
        send_byte(8'h00, 1'b1, "R6 gc ack", 1'b0);
        check(addr_upd == 1'b0, "R6 no upd", {7'd0, addr_upd}, 8'h00);
        pulse_rd(); pulse_clr();
        send_byte(8'h81, 1'b1, "R6 data ack", 1'b0);
        check(rxbuf == 8'h81, "R6 data", rxbuf, 8'h81);
        // R10 read coincides with completion (buffer still full here)
        send_byte(8'hC3, 1'b1, "R10 ack", 1'b1);
        check(rxbuf == 8'hC3, "R10 stored", rxbuf, 8'hC3);
        check(buf_full == 1'b1, "R10 full kept", {7'd0, buf_full}, 8'h01);
        check(ovf == 1'b0, "R10 no ovf", {7'd0, ovf}, 8'h00);
        i2c_stop();
        wait_clk(50);

        check(exp_ack_q.size() == 0, "scoreboard drained", 8'(exp_ack_q.size()), 8'h00);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule